// File: doc/BRIEF.md
# Interleaved I/Q Stream Splitter with Sync Alignment

This block takes one data port that carries I and Q words in turn, one word per rising edge of the data clock. It returns them as paired samples on separate I and Q outputs, together with a one-cycle strobe that marks each new pair. A level-style sync input, sampled on the same clock edges, decides where the I/Q phase starts. Holding sync low keeps the block idle. The first edge at which sync is seen high marks an I word. After that the phase alternates by itself. A source may also drop sync and raise it again once per pair, and each rising edge then re-aligns the phase.

A pairing-mode input selects one of two pairings. In the default mode each I word is paired with the Q word that follows it. In the shifted mode each Q word is paired with the I word that follows it, so the first I word after alignment is dropped. In both modes I words go only to the I output and Q words only to the Q output.

Top module: `iq_deinterleaver`

## Requirements
- R1: While reset is low, and on the first cycle after it, i_out and q_out are zero and pair_vld is 0.
- R2: Until sync_in has been sampled high at least once since reset, input words are ignored: pair_vld stays 0 and the outputs do not change.
- R3: When sync_in is sampled high at an edge after being sampled low at the previous edge, the word taken at that edge is an I word, whatever phase was expected.
- R4: Once aligned, the words taken at successive edges alternate I, Q, I, Q, whatever level sync_in holds.
- R5: With iq_shift = 0, a Q word that follows an unpaired I word gives, one cycle later, pair_vld = 1 with i_out equal to that I word and q_out equal to the Q word.
- R6: With iq_shift = 1, an I word that follows an unpaired Q word gives, one cycle later, pair_vld = 1 with i_out equal to that I word and q_out equal to the Q word. The first I word after alignment is discarded.
- R7: In a cycle where pair_vld is 0, i_out and q_out keep their previous values. An I word never appears on q_out and a Q word never appears on i_out.
- R8: If a forced I word (R3) arrives while an earlier I word is still unpaired, the earlier I word is discarded and only the newer one is paired.
- R9: Toggling sync_in high on every I word and low on every Q word gives the same pairs as holding sync_in high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Data clock; all sampling on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| din | input | DATA_W | Interleaved I/Q input word |
| sync_in | input | 1 | Phase alignment level |
| iq_shift | input | 1 | 0: I paired with the following Q; 1: Q paired with the following I |
| i_out | output | DATA_W | I sample of the latest pair |
| q_out | output | DATA_W | Q sample of the latest pair |
| pair_vld | output | 1 | One-cycle strobe marking a new pair |

## Verification
The bench holds sync low over live data before alignment. A design that did not gate on lock would emit pairs of unaligned words. It then forces a re-alignment onto a slot where a Q word was expected while an I word is still unpaired. A design that ignored the rising edge would swap the channels, and one that kept the stale I word would pair the wrong word. The shifted mode is run from reset so that the dropped first I word and the (I next, Q previous) pairing are both checked. The toggling-sync stream is compared against the same pairs that the steady-high stream produces.

// File: rtl/iq_deint_pkg.sv
package iq_deint_pkg;
   typedef enum logic {
      WORD_I = 1'b0,
      WORD_Q = 1'b1
   } word_kind_e;
endpackage

// File: rtl/iq_phase_tracker.sv
module iq_phase_tracker
   import iq_deint_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sync_in,
   output logic       word_vld,
   output word_kind_e word_kind
);
   logic       sync_q;
   logic       locked_q;
   word_kind_e expect_q;
   logic       sync_rise;

   assign sync_rise = sync_in & ~sync_q;
   assign word_vld  = sync_rise | locked_q;
   assign word_kind = sync_rise ? WORD_I : expect_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sync_q   <= 1'b0;
         locked_q <= 1'b0;
         expect_q <= WORD_I;
      end else begin
         sync_q <= sync_in;
         if (word_vld) begin
            locked_q <= 1'b1;
            expect_q <= (word_kind == WORD_I) ? WORD_Q : WORD_I;
         end
      end
   end

   // R3: a fresh rise of sync always marks an I word
   p_rise_is_i_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $rose(sync_in)) |-> (word_vld && word_kind == WORD_I));

   // R4: back-to-back valid words alternate unless re-aligned
   p_alternate_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && word_vld && $past(word_vld) && !$rose(sync_in))
      |-> (word_kind != $past(word_kind)));

   // R2: nothing is taken before sync has ever been seen high
   p_idle_until_sync_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !$past(word_vld) && !sync_in) |-> !word_vld);
endmodule

// File: rtl/iq_pair_builder.sv
module iq_pair_builder
   import iq_deint_pkg::*;
#(
   parameter int DATA_W = 12
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] din,
   input  logic              word_vld,
   input  word_kind_e        word_kind,
   input  logic              iq_shift,
   output logic [DATA_W-1:0] i_out,
   output logic [DATA_W-1:0] q_out,
   output logic              pair_vld
);
   logic [DATA_W-1:0] i_hold_q, q_hold_q;
   logic              i_pend_q, q_pend_q;
   logic              take_i, take_q, emit_on_q, emit_on_i;

   assign take_i    = word_vld && (word_kind == WORD_I);
   assign take_q    = word_vld && (word_kind == WORD_Q);
   assign emit_on_q = take_q && !iq_shift && i_pend_q;
   assign emit_on_i = take_i &&  iq_shift && q_pend_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         i_hold_q <= '0;
         q_hold_q <= '0;
         i_pend_q <= 1'b0;
         q_pend_q <= 1'b0;
         i_out    <= '0;
         q_out    <= '0;
         pair_vld <= 1'b0;
      end else begin
         pair_vld <= emit_on_q | emit_on_i;
         if (emit_on_q) begin
            i_out <= i_hold_q;
            q_out <= din;
         end
         if (emit_on_i) begin
            i_out <= din;
            q_out <= q_hold_q;
         end
         if (take_i) begin
            i_hold_q <= din;
            i_pend_q <= 1'b1;
            q_pend_q <= 1'b0;
         end
         if (take_q) begin
            q_hold_q <= din;
            q_pend_q <= 1'b1;
            i_pend_q <= 1'b0;
         end
      end
   end

   // R2: no pair without a word taken on the edge before
   p_no_pair_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !word_vld |=> !pair_vld);

   // R7: outputs hold when no word was taken
   p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !word_vld |=> ($stable(i_out) && $stable(q_out)));

   // R5: default mode, the Q word lands on q_out
   p_q_lands_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (take_q && !iq_shift && i_pend_q) |=> (pair_vld && q_out == $past(din)));

   // R6: shifted mode, the I word lands on i_out
   p_i_lands_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (take_i && iq_shift && q_pend_q) |=> (pair_vld && i_out == $past(din)));
endmodule

// File: rtl/iq_deinterleaver.sv
module iq_deinterleaver
   import iq_deint_pkg::*;
#(
   parameter int DATA_W = 12
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] din,
   input  logic              sync_in,
   input  logic              iq_shift,
   output logic [DATA_W-1:0] i_out,
   output logic [DATA_W-1:0] q_out,
   output logic              pair_vld
);
   generate
      if (DATA_W < 1) begin : g_bad_width
         $error("iq_deinterleaver: DATA_W must be at least 1");
      end
   endgenerate

   logic       word_vld;
   word_kind_e word_kind;

   iq_phase_tracker u_phase (
      .clk       (clk),
      .rst_n     (rst_n),
      .sync_in   (sync_in),
      .word_vld  (word_vld),
      .word_kind (word_kind)
   );

   iq_pair_builder #(.DATA_W(DATA_W)) u_pair (
      .clk       (clk),
      .rst_n     (rst_n),
      .din       (din),
      .word_vld  (word_vld),
      .word_kind (word_kind),
      .iq_shift  (iq_shift),
      .i_out     (i_out),
      .q_out     (q_out),
      .pair_vld  (pair_vld)
   );

   // R1: reset leaves the outputs cleared on the next cycle
   p_reset_clear_r1: assert property (@(posedge clk)
      (!rst_n) |=> (!pair_vld && i_out == '0 && q_out == '0));
endmodule

// File: tb/iq_deinterleaver_bench.sv
module iq_deinterleaver_bench;
   localparam int W = 12;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [W-1:0] din = '0;
   logic         sync_in = 1'b0;
   logic         iq_shift = 1'b0;
   logic [W-1:0] i_out, q_out;
   logic         pair_vld;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #2 clk = ~clk;

   iq_deinterleaver #(.DATA_W(W)) u_iq_deinterleaver (
      .clk(clk), .rst_n(rst_n), .din(din), .sync_in(sync_in),
      .iq_shift(iq_shift), .i_out(i_out), .q_out(q_out), .pair_vld(pair_vld)
   );

   // behavioural reference state
   bit           m_sync_prev, m_locked, m_next_i, m_ipend, m_qpend;
   int           m_last_i, m_last_q;
   int           e_i, e_q;
   bit           e_v;

   task automatic model_reset();
      m_sync_prev = 0; m_locked = 0; m_next_i = 1;
      m_ipend = 0; m_qpend = 0; m_last_i = 0; m_last_q = 0;
      e_i = 0; e_q = 0; e_v = 0;
   endtask

   task automatic check(string tag, int act, int exp, string what);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   task automatic compare(string tag);
      check(tag, int'(pair_vld), int'(e_v), "pair_vld");
      check(e_v ? tag : "R7", int'(i_out), e_i, "i_out");
      check(e_v ? tag : "R7", int'(q_out), e_q, "q_out");
   endtask

   task automatic step(bit s, int d, string tag);
      bit rise, vld, is_i;
      @(negedge clk);
      sync_in = s;
      din = W'(d);
      rise = s && !m_sync_prev;
      vld  = rise || m_locked;
      is_i = rise ? 1'b1 : m_next_i;
      e_v  = 0;
      if (vld) begin
         if (!is_i && !iq_shift && m_ipend) begin e_v = 1; e_i = m_last_i; e_q = d; end
         if (is_i && iq_shift && m_qpend)   begin e_v = 1; e_i = d; e_q = m_last_q; end
         if (is_i) begin m_last_i = d; m_ipend = 1; m_qpend = 0; end
         else      begin m_last_q = d; m_qpend = 1; m_ipend = 0; end
         m_locked = 1;
         m_next_i = !is_i;
      end
      m_sync_prev = s;
      @(posedge clk);
      #1;
      compare(tag);
   endtask

   task automatic do_reset(bit shift);
      @(negedge clk);
      rst_n = 0; sync_in = 0; iq_shift = shift; din = '0;
      repeat (2) @(posedge clk);
      #1;
      model_reset();
      compare("R1");
      @(negedge clk);
      rst_n = 1;
      @(posedge clk);
      #1;
      compare("R1");
   endtask

   initial begin
      model_reset();
      do_reset(1'b0);
      // R2: live data with sync low
      for (int k = 0; k < 4; k++) step(0, 12'h300 + k, "R2");
      // R5 / R4: sync held high, I words 0x1nn, Q words 0xAnn
      for (int k = 1; k <= 4; k++) begin
         step(1, 12'h100 + k, "R5");
         step(1, 12'hA00 + k, "R5");
      end
      // R4: sync dropped, phase keeps alternating
      for (int k = 5; k <= 7; k++) begin
         step(0, 12'h100 + k, "R4");
         step(0, 12'hA00 + k, "R4");
      end
      // R9: sync toggles once per pair
      for (int k = 8; k <= 11; k++) begin
         step(1, 12'h100 + k, "R9");
         step(0, 12'hA00 + k, "R9");
      end
      // R3 / R8: realign onto a slot where Q was expected
      step(0, 12'h1F0, "R4");
      step(1, 12'h1F1, "R3");
      step(1, 12'hAF1, "R8");
      step(1, 12'h1F2, "R8");
      step(1, 12'hAF2, "R8");
      // R6: shifted pairing from reset
      do_reset(1'b1);
      step(0, 12'h3FF, "R2");
      for (int k = 1; k <= 5; k++) begin
         step(1, 12'h100 + k, "R6");
         step(1, 12'hA00 + k, "R6");
      end
      step(0, 12'h1E0, "R6");
      step(0, 12'hAE0, "R7");
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end
endmodule